// File: doc/BRIEF.md
# Lane Mask Stack for Divergent SIMD Branches

This block tracks which of the 32 lanes of a SIMD thread processor are active while the lanes follow different sides of a branch. The sequencer issues three commands, each with a 32-bit per-lane predicate. A divergent branch is a push. The push saves the current mask together with the branch predicate and narrows the active mask to the lanes whose predicate bit is set. At the else point, a complement makes the lanes on the other side active. These are the lanes that were active before the branch and whose predicate bit is clear, so lanes that were already off stay off. At the join point, a pop restores the mask that was in force before the branch.

Only lanes whose active bit is set commit results. A zero-path flag tells the sequencer that the side just entered has no live lanes, so it can skip that side. The saved entries sit in a small storage array. The number of saved entries is a parameter with a default of 8. Overflow and underflow are recorded in sticky flags. All outputs are registered, so each command is visible one clock after the edge that samples it.

Top module: `lane_mask_stack`

## Requirements
- R1: After a synchronous reset, the active mask is all ones, depth is 0, and the overflow, underflow and zero-path flags are 0.
- R2: An accepted push makes the active mask equal to the old mask AND the predicate, and raises depth by one, both one clock after the edge that samples it.
- R3: A complement makes the active mask equal to the saved parent mask of the top entry AND NOT the predicate saved with that entry, with depth unchanged. A complement at depth 0 changes nothing.
- R4: An accepted pop restores the saved parent mask of the top entry and lowers depth by one.
- R5: Nested pushes and pops behave last-in first-out up to DEPTH levels. Each pop restores the mask that was in force before its matching push.
- R6: A push at depth DEPTH leaves the mask, the depth and the saved entries unchanged, and sets the overflow flag. The flag stays set until reset.
- R7: A pop at depth 0 leaves the mask unchanged and sets the underflow flag. The flag stays set until reset.
- R8: After an accepted push or complement, the zero-path flag is 1 exactly when the new active mask is zero. An accepted pop clears it. Rejected commands leave it unchanged.
- R9: When several commands are raised in one cycle, push takes priority over complement, and complement takes priority over pop. Only the winning command acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Divergent branch: save mask and predicate, narrow mask |
| comp_i | input | 1 | Else point: switch to the other side of the top entry |
| pop_i | input | 1 | Join point: restore the saved mask |
| pred_i | input | LANES | Per-lane branch predicate, sampled with push |
| active_o | output | LANES | Active lane mask |
| depth_o | output | $clog2(DEPTH+1) | Number of saved entries |
| ovf_o | output | 1 | Sticky: push attempted while full |
| udf_o | output | 1 | Sticky: pop attempted while empty |
| zero_path_o | output | 1 | The path just entered has no active lanes |

## Verification
The bench goes after the corner cases where the stack sits at its limits.

- A push at full depth must not overwrite the top entry. A design that lets it through would lose a parent mask and corrupt a later pop.
- A pop at depth 0 must keep the mask. A faulty design would wrap the depth or load garbage.
- A complement under a parent mask that has holes must keep those holes. A design that takes only NOT predicate would revive lanes that were dead before the branch.
- A predicate of zero must raise the zero-path flag.
- When several commands arrive together, only the winner may act. Mixed commands expose a wrong priority order.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_COMP = 2'd2,
    OP_POP  = 2'd3
  } lms_op_e;
endpackage

// File: rtl/lms_store.sv
module lms_store #(
  parameter int DEPTH = 8,
  parameter int W     = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lms_next.sv
module lms_next
  import lms_pkg::*;
#(
  parameter int LANES = 32
) (
  input  lms_op_e          op,
  input  logic             full,
  input  logic             empty,
  input  logic [LANES-1:0] cur,
  input  logic [LANES-1:0] pred,
  input  logic [LANES-1:0] top_parent,
  input  logic [LANES-1:0] top_pred,
  output logic [LANES-1:0] nxt,
  output logic             accept,
  output logic             sets_zero
);
  always_comb begin
    nxt       = cur;
    accept    = 1'b0;
    sets_zero = 1'b0;
    unique case (op)
      OP_PUSH: if (!full) begin
        accept    = 1'b1;
        nxt       = cur & pred;
        sets_zero = 1'b1;
      end
      OP_COMP: if (!empty) begin
        accept    = 1'b1;
        nxt       = top_parent & ~top_pred;
        sets_zero = 1'b1;
      end
      OP_POP: if (!empty) begin
        accept = 1'b1;
        nxt    = top_parent;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lane_mask_stack.sv
module lane_mask_stack
  import lms_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int DW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             comp_i,
  input  logic             pop_i,
  input  logic [LANES-1:0] pred_i,
  output logic [LANES-1:0] active_o,
  output logic [DW-1:0]    depth_o,
  output logic             ovf_o,
  output logic             udf_o,
  output logic             zero_path_o
);
  lms_op_e          op;
  logic             full, empty, accept, sets_zero;
  logic [LANES-1:0] nxt, top_parent, top_pred;
  logic [DW-1:0]    depth_m1;
  logic [2*LANES-1:0] rd_word;

  // R9: fixed priority push > complement > pop
  always_comb begin
    if (push_i)      op = OP_PUSH;
    else if (comp_i) op = OP_COMP;
    else if (pop_i)  op = OP_POP;
    else             op = OP_NONE;
  end

  assign full     = (depth_o == DW'(DEPTH));
  assign empty    = (depth_o == '0);
  assign depth_m1 = depth_o - DW'(1);

  lms_store #(.DEPTH(DEPTH), .W(2*LANES)) u_store (
    .clk   (clk),
    .we    (op == OP_PUSH && !full),
    .waddr (depth_o[AW-1:0]),
    .wdata ({active_o, pred_i}),
    .raddr (depth_m1[AW-1:0]),
    .rdata (rd_word)
  );

  assign top_parent = rd_word[2*LANES-1:LANES];
  assign top_pred   = rd_word[LANES-1:0];

  lms_next #(.LANES(LANES)) u_next (
    .op         (op),
    .full       (full),
    .empty      (empty),
    .cur        (active_o),
    .pred       (pred_i),
    .top_parent (top_parent),
    .top_pred   (top_pred),
    .nxt        (nxt),
    .accept     (accept),
    .sets_zero  (sets_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o    <= '1;
      depth_o     <= '0;
      ovf_o       <= 1'b0;
      udf_o       <= 1'b0;
      zero_path_o <= 1'b0;
    end else begin
      active_o <= nxt;
      if (accept && op == OP_PUSH) depth_o <= depth_o + DW'(1);
      else if (accept && op == OP_POP) depth_o <= depth_m1;
      if (op == OP_PUSH && full) ovf_o <= 1'b1;
      if (op == OP_POP && empty) udf_o <= 1'b1;
      if (accept && sets_zero)          zero_path_o <= (nxt == '0);
      else if (accept && op == OP_POP)  zero_path_o <= 1'b0;
    end
  end

  // R5: depth never exceeds capacity
  p_depth_bound_r5: assert property (@(posedge clk) disable iff (rst)
    depth_o <= DW'(DEPTH));

  // R2: a push never turns on a lane that was off
  p_push_subset_r2: assert property (@(posedge clk) disable iff (rst)
    (push_i && !full) |=> ((active_o & ~$past(active_o)) == '0) &&
                          (depth_o == $past(depth_o) + DW'(1)));

  // R6: push while full changes nothing but the flag
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (push_i && full) |=> $stable(active_o) && $stable(depth_o) && ovf_o);

  // R7: pop while empty changes nothing but the flag
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && !comp_i && empty) |=> $stable(active_o) && udf_o);

  // R3: complement keeps depth
  p_comp_depth_r3: assert property (@(posedge clk) disable iff (rst)
    (comp_i && !push_i) |=> $stable(depth_o));

  // R8: zero-path flag after an accepted push
  p_zero_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (push_i && !full) |=> (zero_path_o == (active_o == '0)));

  // R6 and R7: sticky flags never fall outside reset
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    udf_o |=> udf_o);
endmodule

// File: tb/lane_mask_stack_bench.sv
module lane_mask_stack_bench;
  localparam int LANES = 32;
  localparam int DEPTH = 8;
  localparam int DW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_i = 1'b0, comp_i = 1'b0, pop_i = 1'b0;
  logic [LANES-1:0] pred_i = '0;
  logic [LANES-1:0] active_o;
  logic [DW-1:0] depth_o;
  logic ovf_o, udf_o, zero_path_o;

  int n_run = 0, n_fail = 0;

  logic [LANES-1:0] s_mask [DEPTH];
  logic [LANES-1:0] s_pred [DEPTH];
  logic [LANES-1:0] m_act;
  int m_depth;
  logic m_ovf, m_udf, m_zero;

  always #10 clk = ~clk;

  lane_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_lane_mask_stack (
    .clk(clk), .rst(rst), .push_i(push_i), .comp_i(comp_i), .pop_i(pop_i),
    .pred_i(pred_i), .active_o(active_o), .depth_o(depth_o), .ovf_o(ovf_o),
    .udf_o(udf_o), .zero_path_o(zero_path_o)
  );

  task automatic model_reset();
    m_act = '1; m_depth = 0; m_ovf = 0; m_udf = 0; m_zero = 0;
  endtask

  task automatic model_step(input logic p, input logic c, input logic q,
                            input logic [LANES-1:0] pr);
    if (p) begin
      if (m_depth == DEPTH) m_ovf = 1;
      else begin
        s_mask[m_depth] = m_act; s_pred[m_depth] = pr;
        m_act = m_act & pr; m_zero = (m_act == '0); m_depth++;
      end
    end else if (c) begin
      if (m_depth != 0) begin
        m_act = s_mask[m_depth-1] & ~s_pred[m_depth-1];
        m_zero = (m_act == '0);
      end
    end else if (q) begin
      if (m_depth == 0) m_udf = 1;
      else begin
        m_act = s_mask[m_depth-1]; m_depth--; m_zero = 0;
      end
    end
  endtask

  task automatic check(input string req);
    n_run++;
    if (active_o !== m_act || depth_o !== DW'(m_depth) || ovf_o !== m_ovf ||
        udf_o !== m_udf || zero_path_o !== m_zero) begin
      n_fail++;
      $display("FAIL %s: act=%h dep=%0d ovf=%b udf=%b zero=%b exp act=%h dep=%0d ovf=%b udf=%b zero=%b",
               req, active_o, depth_o, ovf_o, udf_o, zero_path_o,
               m_act, m_depth, m_ovf, m_udf, m_zero);
    end
  endtask

  task automatic op(input logic p, input logic c, input logic q,
                    input logic [LANES-1:0] pr, input string req);
    push_i = p; comp_i = c; pop_i = q; pred_i = pr;
    model_step(p, c, q, pr);
    @(negedge clk);
    push_i = 0; comp_i = 0; pop_i = 0;
    check(req);
  endtask

  task automatic do_reset();
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    model_reset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'h5eed);
    @(negedge clk);
    do_reset();
    check("R1");
    // R2 push, R3 complement, R4 pop
    op(1, 0, 0, 32'h0F0F_00FF, "R2");
    op(0, 1, 0, 32'h0, "R3");
    op(0, 0, 1, 32'h0, "R4");
    // R3 complement at depth 0 is ignored
    op(0, 1, 0, 32'h1234_5678, "R3");
    // R3 holes of parent preserved in complement; R5 nesting
    op(1, 0, 0, 32'h00FF_FF00, "R5");
    op(1, 0, 0, 32'h0F0F_0F0F, "R5");
    op(0, 1, 0, 32'h0, "R3");
    op(0, 0, 1, 32'h0, "R5");
    op(0, 1, 0, 32'h0, "R3");
    op(0, 0, 1, 32'h0, "R5");
    // R8 zero predicate
    op(1, 0, 0, 32'h0, "R8");
    op(0, 1, 0, 32'h0, "R8");
    op(0, 0, 1, 32'h0, "R8");
    // R5 fill to depth then R6 overflow
    for (int i = 0; i < DEPTH; i++) op(1, 0, 0, ~(32'h1 << i), "R5");
    op(1, 0, 0, 32'h0, "R6");
    op(0, 1, 0, 32'h0, "R6");
    for (int i = 0; i < DEPTH; i++) op(0, 0, 1, 32'h0, "R5");
    // R7 underflow
    op(0, 0, 1, 32'h0, "R7");
    op(0, 0, 0, 32'h0, "R7");
    // R9 priority
    do_reset();
    op(1, 1, 1, 32'hAAAA_5555, "R9");
    op(0, 1, 1, 32'hFFFF_FFFF, "R9");
    op(1, 0, 1, 32'hF0F0_F0F0, "R9");
    op(0, 0, 1, 32'h0, "R9");
    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned k;
      logic [LANES-1:0] pr;
      if (n % 80 == 0) do_reset();
      k = $urandom_range(0, 9);
      pr = ($urandom_range(0, 7) == 0) ? '0 : ($urandom | $urandom);
      case (k)
        0, 1, 2: op(1, 0, 0, pr, "R2");
        3, 4:    op(0, 1, 0, pr, "R3");
        5, 6, 7: op(0, 0, 1, pr, "R4");
        8:       op($urandom_range(0, 1) != 0, 1, 1, pr, "R9");
        default: op(0, 0, 0, pr, "R5");
      endcase
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule